// File: doc/BRIEF.md
# Dual 8-Bit Parallel Port with Register Bus

This peripheral gives a host two 8-bit general-purpose ports, A and B, behind a small synchronous register bus. Each pin of each port can be an input or an output on its own, set by a direction register. A per-port control register picks one of three buffering submodes. Input can be read live from the pins or captured through a two-stage latch on a port strobe. Output can be driven straight from the host write or staged in a holding register until the port strobe.

A bit in the general control register ties the two ports into one 16-bit port, with A as the high byte. In that mode a write to A is staged and shows up on the pins only together with the next write to B. A read of A also takes a snapshot of B, so the host always sees a coherent 16-bit value. Each port has an input pin bus, an output pin bus, a per-pin output enable and a strobe. Strobes are treated as synchronous to the clock, and a strobe must be high for at least one clock.

Top module: `pport_dual`

## Requirements
- R1: After reset every register reads 0x00, every output enable is 0, every output pin is 0 and the read data bus is 0x00.
- R2: Register byte offsets are general control 0x00, service request 0x02, A direction 0x04, B direction 0x06, A control 0x0C, B control 0x0E, A data 0x10, B data 0x12, status 0x1A. General control, service request, direction and control registers store all 8 bits and read back unchanged. Read data appears on the clock after the cycle in which read enable is high.
- R3: Output enable bit n of a port equals bit n of its direction register (1 = output). On a data read, output bits return the port's output register and input bits return the source picked by the submode.
- R4: A read of any other offset returns 0x00, and a write to one changes no register and no pin.
- R5: Submode is control bits [7:6]. With bit 7 set (1x), a data read returns the pins as sampled at the read edge, and the port strobe has no effect.
- R6: Submode 00 input: a strobe rising edge captures the pins into a first latch. One clock later the value moves into the visible latch if that latch is empty. A data read returns the visible latch and empties it. Status bit 0 (A) and bit 1 (B) read 1 while the visible latch is full.
- R7: Submode 00 holds two values. A capture made while the visible latch is full waits in the first latch and moves after the read. A further capture overwrites the first latch.
- R8: In submodes 00 and 1x a data write reaches the output pins on the clock edge that takes the write.
- R9: Submode 01: a data write goes to a holding register and leaves the pins unchanged. A strobe rising edge copies the holding register to the pins. If a write and a strobe edge coincide, the pins take the old holding value. Input bits read the live pins.
- R10: With general control bit 6 set (paired mode), a write to A data is staged and changes no pin. The next write to B data loads A with the staged byte and B with the written byte on the same edge.
- R11: In paired mode a read of A data also snapshots B's read value, and a following read of B data returns that snapshot even if B's pins have changed since.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte offset |
| wrEn | input | 1 | Register write enable |
| rdEn | input | 1 | Register read enable |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| paIn | input | 8 | Port A input pins |
| paOut | output | 8 | Port A output pins |
| paOe | output | 8 | Port A per-pin output enable |
| paStb | input | 1 | Port A strobe |
| pbIn | input | 8 | Port B input pins |
| pbOut | output | 8 | Port B output pins |
| pbOe | output | 8 | Port B per-pin output enable |
| pbStb | input | 1 | Port B strobe |

## Verification
In the double-buffered input submode, a host read that empties the visible latch can land on the same edge as a strobe capture into the first latch. The bench raises the strobe and the read enable in the same cycle while the visible latch holds an older byte. It expects the read to return the older byte, and a read one clock later to return the newly captured byte. A second collision, a holding-register write on the same edge as an output strobe, is judged by the pins taking the previous holding value.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  localparam int BYTE_W   = 8;
  localparam int NPORT    = 2;
  localparam int OFF_GCR  = 'h00;
  localparam int OFF_SRQ  = 'h02;
  localparam int OFF_DIRA = 'h04;
  localparam int OFF_DIRB = 'h06;
  localparam int OFF_CTLA = 'h0C;
  localparam int OFF_CTLB = 'h0E;
  localparam int OFF_DATA = 'h10;
  localparam int OFF_DATB = 'h12;
  localparam int OFF_STAT = 'h1A;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_GCR, SEL_SRQ, SEL_DIRA, SEL_DIRB,
    SEL_CTLA, SEL_CTLB, SEL_DATA, SEL_DATB, SEL_STAT
  } regSel_e;

  typedef struct packed {
    logic             wrGcr;
    logic             wrSrq;
    logic [NPORT-1:0] wrDir;
    logic [NPORT-1:0] wrCtl;
    logic [NPORT-1:0] load;
    logic             stageWr;
    logic [NPORT-1:0] pop;
    logic             snapB;
    logic             rdAny;
  } strobes_t;
endpackage

// File: rtl/dpp_ctrl.sv
module dpp_ctrl
  import dpp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              pairMode,
  output regSel_e           sel,
  output strobes_t          st
);
  always_comb begin
    case (addr)
      ADDR_W'(OFF_GCR):  sel = SEL_GCR;
      ADDR_W'(OFF_SRQ):  sel = SEL_SRQ;
      ADDR_W'(OFF_DIRA): sel = SEL_DIRA;
      ADDR_W'(OFF_DIRB): sel = SEL_DIRB;
      ADDR_W'(OFF_CTLA): sel = SEL_CTLA;
      ADDR_W'(OFF_CTLB): sel = SEL_CTLB;
      ADDR_W'(OFF_DATA): sel = SEL_DATA;
      ADDR_W'(OFF_DATB): sel = SEL_DATB;
      ADDR_W'(OFF_STAT): sel = SEL_STAT;
      default:           sel = SEL_NONE;
    endcase
  end

  logic wrA, wrB, rdA, rdB;
  assign wrA = wrEn && (sel == SEL_DATA);
  assign wrB = wrEn && (sel == SEL_DATB);
  assign rdA = rdEn && (sel == SEL_DATA);
  assign rdB = rdEn && (sel == SEL_DATB);

  always_comb begin
    st          = '0;
    st.wrGcr    = wrEn && (sel == SEL_GCR);
    st.wrSrq    = wrEn && (sel == SEL_SRQ);
    st.wrDir[0] = wrEn && (sel == SEL_DIRA);
    st.wrDir[1] = wrEn && (sel == SEL_DIRB);
    st.wrCtl[0] = wrEn && (sel == SEL_CTLA);
    st.wrCtl[1] = wrEn && (sel == SEL_CTLB);
    // paired mode: A is staged, B commits both bytes together
    st.stageWr  = wrA && pairMode;
    st.load[0]  = pairMode ? wrB : wrA;
    st.load[1]  = wrB;
    st.pop[0]   = rdA;
    st.pop[1]   = rdB;
    st.snapB    = rdA && pairMode;
    st.rdAny    = rdEn;
  end
endmodule

// File: rtl/dpp_port.sv
module dpp_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  input  logic         stb,
  input  logic [W-1:0] dir,
  input  logic [1:0]   submode,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         pop,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] readVal,
  output logic         full
);
  logic         stbPrev, stbRise, dbIn, dbOut, moveNow;
  logic [W-1:0] stage1, vis, hold, outReg;
  logic         stage1Full, visFull;

  assign stbRise = stb && !stbPrev;
  assign dbIn    = (submode == 2'b00);
  assign dbOut   = (submode == 2'b01);
  assign moveNow = dbIn && stage1Full && !visFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbPrev    <= 1'b0;
      stage1     <= '0;
      stage1Full <= 1'b0;
      vis        <= '0;
      visFull    <= 1'b0;
      hold       <= '0;
      outReg     <= '0;
    end else begin
      stbPrev <= stb;
      if (dbIn && stbRise) begin
        stage1     <= pinIn;
        stage1Full <= 1'b1;
      end else if (moveNow) begin
        stage1Full <= 1'b0;
      end
      if (moveNow) begin
        vis     <= stage1;
        visFull <= 1'b1;
      end else if (pop) begin
        visFull <= 1'b0;
      end
      if (load && dbOut)        hold   <= loadVal;
      else if (load)            outReg <= loadVal;
      if (dbOut && stbRise)     outReg <= hold;
    end
  end

  assign pinOut  = outReg;
  assign full    = visFull;
  assign readVal = (dir & outReg) | (~dir & (dbIn ? vis : pinIn));

  p_single_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (load && !dbOut) |=> (pinOut == $past(loadVal)));
  p_hold_until_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (load && dbOut && !stbRise) |=> $stable(pinOut));
  p_empty_by_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(visFull) |-> $past(pop));
endmodule

// File: rtl/dpp_datapath.sv
module dpp_datapath
  import dpp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regSel_e           sel,
  input  strobes_t          st,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] pinIn  [NPORT],
  input  logic              stb    [NPORT],
  output logic [BYTE_W-1:0] pinOut [NPORT],
  output logic [BYTE_W-1:0] pinOe  [NPORT],
  output logic [BYTE_W-1:0] rdData,
  output logic              pairMode
);
  logic [BYTE_W-1:0] gcrReg, srqReg, stageHi, shadowB, rdMux, rdQ;
  logic [BYTE_W-1:0] dirReg  [NPORT];
  logic [BYTE_W-1:0] ctlReg  [NPORT];
  logic [BYTE_W-1:0] loadVal [NPORT];
  logic [BYTE_W-1:0] portRd  [NPORT];
  logic [NPORT-1:0]  full;

  assign pairMode   = gcrReg[6];
  assign loadVal[0] = pairMode ? stageHi : wrData;
  assign loadVal[1] = wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gcrReg  <= '0;
      srqReg  <= '0;
      stageHi <= '0;
      shadowB <= '0;
      for (int i = 0; i < NPORT; i++) begin
        dirReg[i] <= '0;
        ctlReg[i] <= '0;
      end
    end else begin
      if (st.wrGcr)   gcrReg  <= wrData;
      if (st.wrSrq)   srqReg  <= wrData;
      if (st.stageWr) stageHi <= wrData;
      if (st.snapB)   shadowB <= portRd[1];
      for (int i = 0; i < NPORT; i++) begin
        if (st.wrDir[i]) dirReg[i] <= wrData;
        if (st.wrCtl[i]) ctlReg[i] <= wrData;
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpp_port #(.W(BYTE_W)) u_port (
      .clk     (clk),
      .rstN    (rstN),
      .pinIn   (pinIn[p]),
      .stb     (stb[p]),
      .dir     (dirReg[p]),
      .submode (ctlReg[p][7:6]),
      .load    (st.load[p]),
      .loadVal (loadVal[p]),
      .pop     (st.pop[p]),
      .pinOut  (pinOut[p]),
      .readVal (portRd[p]),
      .full    (full[p])
    );
    assign pinOe[p] = dirReg[p];
  end

  always_comb begin
    case (sel)
      SEL_GCR:  rdMux = gcrReg;
      SEL_SRQ:  rdMux = srqReg;
      SEL_DIRA: rdMux = dirReg[0];
      SEL_DIRB: rdMux = dirReg[1];
      SEL_CTLA: rdMux = ctlReg[0];
      SEL_CTLB: rdMux = ctlReg[1];
      SEL_DATA: rdMux = portRd[0];
      SEL_DATB: rdMux = pairMode ? shadowB : portRd[1];
      SEL_STAT: rdMux = {{(BYTE_W-NPORT){1'b0}}, full};
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdQ <= '0;
    else if (st.rdAny) rdQ <= rdMux;
  end
  assign rdData = rdQ;

  p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdAny && sel == SEL_NONE) |=> (rdData == '0));
  p_staged_no_pin_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.stageWr && ctlReg[0][7:6] != 2'b01) |=> $stable(pinOut[0]));
endmodule

// File: rtl/pport_dual.sv
module pport_dual
  import dpp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [7:0]        paIn,
  output logic [7:0]        paOut,
  output logic [7:0]        paOe,
  input  logic              paStb,
  input  logic [7:0]        pbIn,
  output logic [7:0]        pbOut,
  output logic [7:0]        pbOe,
  input  logic              pbStb
);
  regSel_e           sel;
  strobes_t          st;
  logic              pairMode;
  logic [BYTE_W-1:0] pinIn  [NPORT];
  logic              stb    [NPORT];
  logic [BYTE_W-1:0] pinOut [NPORT];
  logic [BYTE_W-1:0] pinOe  [NPORT];

  assign pinIn[0] = paIn;
  assign pinIn[1] = pbIn;
  assign stb[0]   = paStb;
  assign stb[1]   = pbStb;
  assign paOut    = pinOut[0];
  assign pbOut    = pinOut[1];
  assign paOe     = pinOe[0];
  assign pbOe     = pinOe[1];

  dpp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr     (addr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .pairMode (pairMode),
    .sel      (sel),
    .st       (st)
  );

  dpp_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sel      (sel),
    .st       (st),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .stb      (stb),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .rdData   (rdData),
    .pairMode (pairMode)
  );
endmodule

// File: tb/pport_dual_bench.sv
`timescale 1ns/1ps
module pport_dual_bench;
  localparam logic [5:0] A_GCR = 6'h00, A_SRQ = 6'h02, A_DIRA = 6'h04, A_DIRB = 6'h06,
                         A_CTLA = 6'h0C, A_CTLB = 6'h0E, A_DATA = 6'h10, A_DATB = 6'h12,
                         A_STAT = 6'h1A;

  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, paStb = 1'b0, pbStb = 1'b0;
  logic [7:0] wrData = '0, paIn = '0, pbIn = '0;
  logic [7:0] rdData, paOut, paOe, pbOut, pbOe;
  int nChk = 0, nBad = 0;
  logic [7:0] v;
  logic [7:0] dirM [2];
  logic [7:0] outM [2];

  always #2.5 clk = ~clk;

  pport_dual u_pport_dual (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData),
    .paIn(paIn), .paOut(paOut), .paOe(paOe), .paStb(paStb),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe), .pbStb(pbStb)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic pulseA();
    @(negedge clk); paStb = 1'b1;
    @(negedge clk); paStb = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] d, input logic [7:0] o,
                                         input logic [7:0] pins);
    return (d & o) | (~d & pins);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: got hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 paOe", paOe, 8'h00);
    chk("R1 pbOe", pbOe, 8'h00);
    chk("R1 paOut", paOut, 8'h00);
    rd(A_GCR, v);  chk("R1 gcr", v, 8'h00);
    rd(A_CTLB, v); chk("R1 ctlB", v, 8'h00);
    rd(A_DIRA, v); chk("R1 dirA", v, 8'h00);

    // R2 register readback
    wr(A_GCR, 8'h81);  rd(A_GCR, v);  chk("R2 gcr", v, 8'h81);
    wr(A_SRQ, 8'h5A);  rd(A_SRQ, v);  chk("R2 srq", v, 8'h5A);
    wr(A_DIRB, 8'hF0); rd(A_DIRB, v); chk("R2 dirB", v, 8'hF0);
    chk("R3 pbOe follows dir", pbOe, 8'hF0);
    wr(A_CTLA, 8'h3C); rd(A_CTLA, v); chk("R2 ctlA", v, 8'h3C);
    wr(A_GCR, 8'h00);  wr(A_DIRB, 8'h00);

    // R4 unmapped offsets
    rd(6'h08, v); chk("R4 read 08", v, 8'h00);
    rd(6'h1C, v); chk("R4 read 1C", v, 8'h00);
    rd(6'h01, v); chk("R4 read 01", v, 8'h00);
    wr(6'h08, 8'hFF); wr(6'h05, 8'hFF);
    rd(A_DIRA, v); chk("R4 dirA untouched", v, 8'h00);
    rd(A_GCR, v);  chk("R4 gcr untouched", v, 8'h00);
    chk("R4 pins untouched", paOut, 8'h00);

    // R3/R5/R8 random traffic in submode 1x
    wr(A_CTLA, 8'h80); wr(A_CTLB, 8'h80);
    for (int i = 0; i < 2; i++) begin dirM[i] = '0; outM[i] = '0; end
    for (int it = 0; it < 300; it++) begin
      int p;
      logic [7:0] rv;
      p = int'($urandom % 2);
      rv = 8'($urandom);
      case ($urandom % 3)
        0: begin wr(p == 0 ? A_DIRA : A_DIRB, rv); dirM[p] = rv; end
        1: begin wr(p == 0 ? A_DATA : A_DATB, rv); outM[p] = rv; end
        default: begin if (p == 0) paIn = rv; else pbIn = rv; end
      endcase
      chk("R3 oe", p == 0 ? paOe : pbOe, dirM[p]);
      chk("R8 pins", p == 0 ? paOut : pbOut, outM[p]);
      rd(p == 0 ? A_DATA : A_DATB, v);
      chk("R5 R3 read", v, expRead(dirM[p], outM[p], p == 0 ? paIn : pbIn));
    end

    // R6 double-buffered input on port A
    wr(A_CTLA, 8'h00); wr(A_DIRA, 8'h00);
    paIn = 8'h3C; pulseA(); tick();
    paIn = 8'hFF;
    rd(A_STAT, v); chk("R6 status full", v, 8'h01);
    rd(A_DATA, v); chk("R6 latched read", v, 8'h3C);
    rd(A_STAT, v); chk("R6 status empty", v, 8'h00);

    // R7 two-deep with overwrite of the first latch
    paIn = 8'h11; pulseA(); tick();
    paIn = 8'h22; pulseA(); tick();
    paIn = 8'h33; pulseA(); tick();
    paIn = 8'h77;
    rd(A_DATA, v); chk("R7 first value", v, 8'h11);
    tick();
    rd(A_DATA, v); chk("R7 overwritten second", v, 8'h33);
    tick();
    rd(A_STAT, v); chk("R7 drained", v, 8'h00);

    // R6 read and capture on the same edge
    paIn = 8'h44; pulseA(); tick();
    paIn = 8'h55;
    @(negedge clk); paStb = 1'b1; addr = A_DATA; rdEn = 1'b1;
    @(negedge clk); paStb = 1'b0; rdEn = 1'b0; v = rdData;
    chk("R6 collide old", v, 8'h44);
    tick();
    rd(A_DATA, v); chk("R6 collide new", v, 8'h55);

    // R3/R8 mixed directions in submode 00
    wr(A_DIRA, 8'h0F); wr(A_DATA, 8'hA5);
    chk("R8 single buffered 00", paOut, 8'hA5);
    paIn = 8'h99; pulseA(); tick();
    rd(A_DATA, v); chk("R3 mixed read", v, 8'h95);

    // R9 double-buffered output
    wr(A_CTLA, 8'h40); wr(A_DIRA, 8'hFF);
    wr(A_DATA, 8'h3C); chk("R9 held", paOut, 8'hA5);
    pulseA();          chk("R9 strobe moves", paOut, 8'h3C);
    wr(A_DATA, 8'h66); chk("R9 held again", paOut, 8'h3C);
    @(negedge clk); paStb = 1'b1; addr = A_DATA; wrData = 8'h5A; wrEn = 1'b1;
    @(negedge clk); paStb = 1'b0; wrEn = 1'b0;
    chk("R9 collide takes old hold", paOut, 8'h66);
    pulseA();          chk("R9 new hold", paOut, 8'h5A);
    wr(A_DIRA, 8'h00); paIn = 8'hC3;
    rd(A_DATA, v); chk("R9 unlatched input", v, 8'hC3);

    // R5 strobe ignored in 1x
    wr(A_CTLA, 8'h80); wr(A_DIRA, 8'hFF); wr(A_DATA, 8'h12);
    paIn = 8'hE7; pulseA(); tick();
    chk("R5 pins kept", paOut, 8'h12);
    rd(A_STAT, v); chk("R5 no capture", v, 8'h00);
    wr(A_DIRA, 8'h00);
    rd(A_DATA, v); chk("R5 live pins", v, 8'hE7);

    // R10 paired write
    wr(A_DIRA, 8'hFF); wr(A_CTLB, 8'h80); wr(A_DIRB, 8'hFF);
    wr(A_DATB, 8'h00);
    wr(A_GCR, 8'h40);
    wr(A_DATA, 8'hDE);
    chk("R10 A staged", paOut, 8'h12);
    wr(A_DATB, 8'hAD);
    chk("R10 A commit", paOut, 8'hDE);
    chk("R10 B commit", pbOut, 8'hAD);

    // R11 paired read snapshot
    wr(A_DIRA, 8'h00); wr(A_DIRB, 8'h00);
    paIn = 8'h12; pbIn = 8'h34;
    rd(A_DATA, v); chk("R11 high byte", v, 8'h12);
    pbIn = 8'h99;
    rd(A_DATB, v); chk("R11 snapshot", v, 8'h34);
    wr(A_GCR, 8'h00);
    rd(A_DATB, v); chk("R11 unpaired live", v, 8'h99);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule